// File: doc/BRIEF.md
# Frame Dirty Region Watcher

This block watches the write traffic going into a frame buffer. It raises a per-frame dirty flag when a write could change what is on screen. The flag only counts while the compression logic runs in frame-dirty mode. A single configuration word holds two things. The first is a top-of-region address at 1 KiB granularity. The second is an enable bit that limits the watch to the region from address 0 up to, but not including, that top.

When the check is enabled, a write counts only if its address bits [23:10] are strictly below the programmed top field. A write at or above the top is ignored. When the check is disabled, every frame-buffer write counts. A frame-start pulse closes the current frame. On that pulse the accumulated flag moves to a registered result output and the accumulator clears. A write in the same cycle as the pulse belongs to the new frame.

The block also flags one misconfiguration: the enable bit set while frame-dirty mode is off.

Top module: `dirty_region_watch`

## Requirements
- R1: After synchronous reset, `cfg_rd_data`, `dirty_now`, `frame_dirty` and `cfg_error` are all zero, so the region check is disabled.
- R2: A cycle with `cfg_wr_en` high stores `cfg_wr_data[23:10]` as the top field and `cfg_wr_data[0]` as the enable bit. From the next cycle `cfg_rd_data` returns these at the same positions, and bits [31:24] and [9:1] read as zero.
- R3: With frame-dirty mode high and enable set, a write whose address bits [23:10] are strictly less than the top field sets `dirty_now` in the following cycle.
- R4: With enable set, a write whose address bits [23:10] are equal to or greater than the top field never sets `dirty_now`. With top = 0, no write sets it.
- R5: With enable clear and frame-dirty mode high, any write sets `dirty_now` in the following cycle.
- R6: With frame-dirty mode low, no write sets `dirty_now`.
- R7: Once set, `dirty_now` stays set until a frame-start pulse.
- R8: On a frame-start pulse, `frame_dirty` takes the value `dirty_now` held before the pulse, and `dirty_now` clears. A qualifying write in the same cycle as the pulse sets `dirty_now` for the new frame instead.
- R9: `cfg_error` is high in the cycle after any cycle in which the enable bit is set while frame-dirty mode is low, and is low otherwise.
- R10: A frame-buffer write in the same cycle as a configuration write is judged against the configuration held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration word write strobe |
| cfg_wr_data | input | 32 | Configuration word: top at [23:10], enable at [0] |
| cfg_rd_data | output | 32 | Readback of the configuration word |
| fb_wr_valid | input | 1 | Frame-buffer write strobe |
| fb_wr_addr | input | 24 | Byte address of the frame-buffer write |
| fdirty_mode | input | 1 | High while compression runs in frame-dirty mode |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| dirty_now | output | 1 | Dirty flag for the frame in progress |
| frame_dirty | output | 1 | Dirty result of the frame that last ended |
| cfg_error | output | 1 | Enable set while frame-dirty mode is off |

## Verification
The assertions assume at most one frame-buffer write per cycle. They also assume `fb_wr_addr` and `fdirty_mode` are known whenever `fb_wr_valid` is high. The outside-region property compares the address against the stored top field, so it relies on R10's rule that the stored value applies during the cycle of a configuration write. The stimulus drives every input to a defined value on every cycle, including idle ones. It switches mode and configuration only between edges. It places addresses exactly at the top boundary and one byte below it, so that strict-less-than is tested at both sides.

// File: rtl/dv_pkg.sv
package dv_pkg;
  localparam int DV_DATA_W    = 32;
  localparam int DV_ADDR_W    = 24;
  localparam int DV_GRAN_LOG2 = 10;
endpackage

// File: rtl/dv_top_reg.sv
module dv_top_reg #(
  parameter int DATA_W    = dv_pkg::DV_DATA_W,
  parameter int ADDR_W    = dv_pkg::DV_ADDR_W,
  parameter int GRAN_LOG2 = dv_pkg::DV_GRAN_LOG2,
  localparam int TOP_W    = ADDR_W - GRAN_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [TOP_W-1:0]  top_q,
  output logic              en_q,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      top_q <= '0;
      en_q  <= 1'b0;
    end else if (wr_en) begin
      top_q <= wr_data[ADDR_W-1:GRAN_LOG2];
      en_q  <= wr_data[0];
    end
  end

  always_comb begin
    rd_data                       = '0;
    rd_data[ADDR_W-1:GRAN_LOG2]   = top_q;
    rd_data[0]                    = en_q;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_data[DATA_W-1:ADDR_W] == '0) && (rd_data[GRAN_LOG2-1:1] == '0)); // R2
  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (en_q == $past(wr_data[0]))); // R2
endmodule

// File: rtl/dv_region_cmp.sv
module dv_region_cmp #(
  parameter int ADDR_W    = dv_pkg::DV_ADDR_W,
  parameter int GRAN_LOG2 = dv_pkg::DV_GRAN_LOG2,
  localparam int TOP_W    = ADDR_W - GRAN_LOG2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [TOP_W-1:0]  top,
  input  logic              en,
  output logic              counts
);
  logic [TOP_W-1:0] blk;
  logic             below;
  assign blk    = addr[ADDR_W-1:GRAN_LOG2];
  assign below  = (blk < top);
  assign counts = !en || below;
endmodule

// File: rtl/dv_dirty_track.sv
module dv_dirty_track (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic frame_start,
  output logic dirty_now,
  output logic frame_dirty
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dirty_now   <= 1'b0;
      frame_dirty <= 1'b0;
    end else if (frame_start) begin
      frame_dirty <= dirty_now;
      dirty_now   <= hit;
    end else if (hit) begin
      dirty_now   <= 1'b1;
    end
  end

  AST_HOLD_DIRTY: assert property (@(posedge clk) disable iff (rst)
    (dirty_now && !frame_start) |=> dirty_now); // R7
  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (frame_dirty == $past(dirty_now))); // R8
endmodule

// File: rtl/dirty_region_watch.sv
module dirty_region_watch #(
  parameter int DATA_W    = dv_pkg::DV_DATA_W,
  parameter int ADDR_W    = dv_pkg::DV_ADDR_W,
  parameter int GRAN_LOG2 = dv_pkg::DV_GRAN_LOG2,
  localparam int TOP_W    = ADDR_W - GRAN_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [DATA_W-1:0] cfg_wr_data,
  output logic [DATA_W-1:0] cfg_rd_data,
  input  logic              fb_wr_valid,
  input  logic [ADDR_W-1:0] fb_wr_addr,
  input  logic              fdirty_mode,
  input  logic              frame_start,
  output logic              dirty_now,
  output logic              frame_dirty,
  output logic              cfg_error
);
  logic [TOP_W-1:0] top_q;
  logic             en_q;
  logic             counts;
  logic             hit;

  dv_top_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_reg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .top_q(top_q), .en_q(en_q), .rd_data(cfg_rd_data)
  );

  dv_region_cmp #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_cmp (
    .addr(fb_wr_addr), .top(top_q), .en(en_q), .counts(counts)
  );

  assign hit = fb_wr_valid && fdirty_mode && counts;

  dv_dirty_track u_trk (
    .clk(clk), .rst(rst), .hit(hit), .frame_start(frame_start),
    .dirty_now(dirty_now), .frame_dirty(frame_dirty)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_error <= 1'b0;
    else     cfg_error <= en_q && !fdirty_mode;
  end

  AST_MODE_GATE: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && !dirty_now && !fdirty_mode) |=> !dirty_now); // R6
  AST_OUTSIDE_NO_MARK: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && !dirty_now && en_q &&
     (fb_wr_addr[ADDR_W-1:GRAN_LOG2] >= cfg_rd_data[ADDR_W-1:GRAN_LOG2])) |=> !dirty_now); // R4
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !fb_wr_valid) |=> !dirty_now); // R8
  AST_CFG_ERR: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd_data[0] && !fdirty_mode) |=> cfg_error); // R9
endmodule

// File: tb/tb_dirty_region_watch.sv
module tb_dirty_region_watch;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr_en;
  logic [31:0] cfg_wr_data;
  logic [31:0] cfg_rd_data;
  logic        fb_wr_valid;
  logic [23:0] fb_wr_addr;
  logic        fdirty_mode;
  logic        frame_start;
  logic        dirty_now;
  logic        frame_dirty;
  logic        cfg_error;

  always #2.5 clk = ~clk;

  dirty_region_watch dut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .fb_wr_valid(fb_wr_valid), .fb_wr_addr(fb_wr_addr),
    .fdirty_mode(fdirty_mode), .frame_start(frame_start), .dirty_now(dirty_now),
    .frame_dirty(frame_dirty), .cfg_error(cfg_error)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_top = 0, m_en = 0, m_now = 0, m_prev = 0, m_err = 0;
  always @(posedge clk) begin
    int hit;
    cycles++;
    if (rst) begin
      m_top = 0; m_en = 0; m_now = 0; m_prev = 0; m_err = 0;
    end else begin
      hit = (fb_wr_valid && fdirty_mode &&
             (m_en == 0 || int'(fb_wr_addr / 1024) < m_top)) ? 1 : 0;
      m_err = (m_en != 0 && !fdirty_mode) ? 1 : 0;
      if (frame_start) begin
        m_prev = m_now;
        m_now  = hit;
      end else if (hit != 0) m_now = 1;
      if (cfg_wr_en) begin
        m_top = int'(cfg_wr_data[23:10]);
        m_en  = int'(cfg_wr_data[0]);
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(cur_req, "cfg_rd_data", int'(cfg_rd_data), m_top * 1024 + m_en);
    chk(cur_req, "dirty_now", int'(dirty_now), m_now);
    chk(cur_req, "frame_dirty", int'(frame_dirty), m_prev);
    chk(cur_req, "cfg_error", int'(cfg_error), m_err);
  endtask

  task automatic idle();
    cfg_wr_en = 0; cfg_wr_data = '0; fb_wr_valid = 0; fb_wr_addr = '0; frame_start = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    compare_all();
    idle();
  endtask

  task automatic cfg(input int top, input bit en);
    cfg_wr_en = 1; cfg_wr_data = {8'h00, 14'(top), 9'h000, en};
    step();
  endtask

  task automatic wr(input int addr);
    fb_wr_valid = 1; fb_wr_addr = 24'(addr);
    step();
  endtask

  task automatic fstart();
    frame_start = 1;
    step();
  endtask

  initial begin
    #20000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1; idle(); fdirty_mode = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    cur_req = "R1";
    chk("R1", "reset rd", int'(cfg_rd_data), 0);
    chk("R1", "reset dirty", int'(dirty_now), 0);
    chk("R1", "reset frame_dirty", int'(frame_dirty), 0);
    chk("R1", "reset err", int'(cfg_error), 0);

    cur_req = "R2";
    cfg_wr_en = 1; cfg_wr_data = 32'hFFFF_FFFF; step();
    chk("R2", "reserved masked", int'(cfg_rd_data), 32'h00FF_FC01);

    cur_req = "R9";
    step();
    chk("R9", "enable with mode off", int'(cfg_error), 1);

    cur_req = "R6";
    for (int i = 0; i < 4; i++) wr(i * 4096);
    chk("R6", "mode off no mark", int'(dirty_now), 0);

    fdirty_mode = 1;
    cur_req = "R4";
    cfg(0, 1);
    wr(0); wr(24'hFFFFFF);
    chk("R4", "top zero blocks all", int'(dirty_now), 0);
    cfg(8, 1);
    wr(8 * 1024); wr(20 * 1024 + 5);
    chk("R4", "at top no mark", int'(dirty_now), 0);

    cur_req = "R3";
    wr(8 * 1024 - 1);
    chk("R3", "one byte below top marks", int'(dirty_now), 1);

    cur_req = "R7";
    for (int i = 0; i < 3; i++) step();
    chk("R7", "held", int'(dirty_now), 1);

    cur_req = "R8";
    fstart();
    chk("R8", "captured", int'(frame_dirty), 1);
    chk("R8", "cleared", int'(dirty_now), 0);
    frame_start = 1; fb_wr_valid = 1; fb_wr_addr = 24'd100; step();
    chk("R8", "same-cycle write new frame", int'(dirty_now), 1);
    chk("R8", "empty frame captured", int'(frame_dirty), 0);
    fstart();

    cur_req = "R5";
    cfg(3, 0);
    wr(24'hABCDEF);
    chk("R5", "disabled check marks", int'(dirty_now), 1);
    fstart();

    cur_req = "R10";
    cfg(2, 1);
    cfg_wr_en = 1; cfg_wr_data = 32'h0000_FC01; fb_wr_valid = 1; fb_wr_addr = 24'd5000;
    step();
    chk("R10", "old top applies", int'(dirty_now), 0);
    wr(5000);
    chk("R10", "new top applies", int'(dirty_now), 1);

    cur_req = "R9";
    fdirty_mode = 0; step(); step();
    chk("R9", "misconfig flagged", int'(cfg_error), 1);
    cfg(2, 0); step();
    chk("R9", "cleared when disabled", int'(cfg_error), 0);

    cur_req = "R3";
    fdirty_mode = 1; fstart(); cfg(100, 1);
    for (int i = 0; i < 200; i++) begin
      if ((i % 7) == 0) frame_start = 1;
      fb_wr_valid = (i % 3) != 0;
      fb_wr_addr = 24'((i * 7919) % 200000);
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule